// File: doc/BRIEF.md
# Memory Card Address Window Decoder

This block sits between an 18-bit byte-addressed system bus and a memory card. For each bus address it decides whether the card should answer. When the card answers, the block supplies the word address inside the card. The bus address lines are active-low, and the block inverts them before any comparison.

The card's main storage starts at a base chosen by a 5-bit bank setting, in steps of 4K words. It extends over an installed capacity of 16K to 64K words. The main window never reaches into the I/O page, which starts at word 124K. A separate option lets the card also serve the lowest one or two kilowords of the I/O page as ordinary read/write storage. Those hits are mapped into their own local region and flagged on a separate output.

The decode itself is combinational. A parameter adds one register stage on the outputs, and that stage is enabled by default.

Top module: `memwin_decoder`

## Requirements
- R1: While `rst_n` is low, `sel`, `local_addr` and `iopage_hit` are all zero.
- R2: Let w be the bus word address, ~`bus_addr_n`[17:1]. Let base be `bank_sel`×4096. With `bank_sel` ≤ 28, `sel` is 1 when w ≥ base and w < base + capacity. In that case `local_addr` equals w − base, with bit 16 clear.
- R3: Bus address bit 0 (the byte lane) has no effect on any output.
- R4: `cap_sel` codes 0, 1, 2 and 3 set capacities of 16K, 32K, 48K and 64K words.
- R5: The main window never matches w ≥ 126976 (124K), even when base + capacity goes past it.
- R6: `iopage_opt` = 1 matches 126976 ≤ w < 128000. `iopage_opt` = 2 matches 126976 ≤ w < 129024. Codes 0 and 3 match no I/O-page address.
- R7: On an I/O-page match, `sel` and `iopage_hit` are 1, and `local_addr` = 65536 + (w − 126976).
- R8: With `bank_sel` > 28, `sel` and `iopage_hit` stay 0 for every address and every option.
- R9: With `REG_OUT` = 1, the outputs follow a change of the inputs at the next rising clock edge and not before.
- R10: Whenever `sel` is 0, `local_addr` is 0 and `iopage_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| bus_addr_n | input | 18 | Bus byte address, active-low |
| bank_sel | input | 5 | Starting bank, base = value × 4K words |
| cap_sel | input | 2 | Installed capacity, (value+1) × 16K words |
| iopage_opt | input | 2 | I/O-page storage: 0 none, 1 one kiloword, 2 two kilowords, 3 none |
| sel | output | 1 | Address belongs to this card |
| local_addr | output | 17 | Card-local word address |
| iopage_hit | output | 1 | Match lies in the I/O-page storage window |

## Verification
The assertions assume that the settings inputs and the address are settled when each clock edge samples them. They are not expected to hold across values that are still changing within a cycle. The byte-lane check also assumes that only bit 0 moves between two consecutive samples. The bench meets both conditions: it changes every input at the falling edge, holds it for at least one full period, and flips the byte lane on its own while the other inputs stay constant.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int ADDR_W        = 18;
  localparam int WORD_W        = ADDR_W - 1;
  localparam int BANK_W        = 5;
  localparam int BANK_SHIFT    = 12;
  localparam int MAX_BANK      = 28;
  localparam int CAP_W         = 2;
  localparam int CAP_UNIT_LOG2 = 14;
  localparam int MAIN_W        = CAP_UNIT_LOG2 + CAP_W;
  localparam int IO_OPT_W      = 2;
  localparam int IO_BANK       = 31;
  localparam int IO_UNIT_LOG2  = 10;
  localparam int IO_OFF_W      = IO_UNIT_LOG2 + 1;
  localparam int LOCAL_W       = MAIN_W + 1;

  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [WORD_W:0]     span_t;
  typedef logic [MAIN_W-1:0]   main_t;
  typedef logic [IO_OFF_W-1:0] io_off_t;
  typedef logic [LOCAL_W-1:0]  local_t;

  localparam word_t IO_BASE = word_t'(IO_BANK << BANK_SHIFT);

  function automatic word_t bank_base(input logic [BANK_W-1:0] b);
    return word_t'(b) << BANK_SHIFT;
  endfunction

  function automatic span_t cap_words(input logic [CAP_W-1:0] c);
    return (span_t'(c) + span_t'(1)) << CAP_UNIT_LOG2;
  endfunction

  function automatic span_t io_span(input logic [IO_OPT_W-1:0] o);
    case (o)
      IO_OPT_W'(1): return span_t'(1) << IO_UNIT_LOG2;
      IO_OPT_W'(2): return span_t'(2) << IO_UNIT_LOG2;
      default:      return '0;
    endcase
  endfunction
endpackage

// File: rtl/memwin_main_cmp.sv
module memwin_main_cmp
  import memwin_pkg::*;
(
  input  word_t              word_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [CAP_W-1:0]   cap_i,
  output logic               bank_ok_o,
  output logic               hit_o,
  output main_t              local_o
);
  word_t base;
  span_t end_raw;
  span_t limit;

  always_comb begin
    base      = bank_base(bank_i);
    end_raw   = span_t'(base) + cap_words(cap_i);
    limit     = (end_raw > span_t'(IO_BASE)) ? span_t'(IO_BASE) : end_raw;
    bank_ok_o = (bank_i <= BANK_W'(MAX_BANK));
    hit_o     = bank_ok_o && (word_i >= base) && (span_t'(word_i) < limit);
    local_o   = main_t'(word_i - base);
  end
endmodule

// File: rtl/memwin_io_cmp.sv
module memwin_io_cmp
  import memwin_pkg::*;
(
  input  word_t               word_i,
  input  logic [IO_OPT_W-1:0] opt_i,
  input  logic                bank_ok_i,
  output logic                hit_o,
  output io_off_t             off_o
);
  word_t off;

  always_comb begin
    off   = word_i - IO_BASE;
    hit_o = bank_ok_i && (word_i >= IO_BASE) && (span_t'(off) < io_span(opt_i));
    off_o = io_off_t'(off);
  end
endmodule

// File: rtl/memwin_out.sv
module memwin_out
  import memwin_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_d,
  input  local_t local_d,
  input  logic   io_d,
  output logic   sel_o,
  output local_t local_o,
  output logic   io_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sel_o   <= 1'b0;
          local_o <= '0;
          io_o    <= 1'b0;
        end else begin
          sel_o   <= sel_d;
          local_o <= local_d;
          io_o    <= io_d;
        end
      end
    end else begin : g_comb
      always_comb begin
        sel_o   = sel_d;
        local_o = local_d;
        io_o    = io_d;
      end
    end
  endgenerate

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_o |-> (local_o == '0) && !io_o);

  a_r7_io_in_upper_region: assert property (@(posedge clk) disable iff (!rst_n)
    io_o |-> sel_o && local_o[LOCAL_W-1]);
endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
  import memwin_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr_n,
  input  logic [BANK_W-1:0]    bank_sel,
  input  logic [CAP_W-1:0]     cap_sel,
  input  logic [IO_OPT_W-1:0]  iopage_opt,
  output logic                 sel,
  output logic [LOCAL_W-1:0]   local_addr,
  output logic                 iopage_hit
);
  word_t   word_addr;
  logic    bank_ok;
  logic    main_hit;
  main_t   main_local;
  logic    io_hit;
  io_off_t io_off;
  logic    sel_d;
  local_t  local_d;

  assign word_addr = ~bus_addr_n[ADDR_W-1:1];

  memwin_main_cmp u_main (
    .word_i    (word_addr),
    .bank_i    (bank_sel),
    .cap_i     (cap_sel),
    .bank_ok_o (bank_ok),
    .hit_o     (main_hit),
    .local_o   (main_local)
  );

  memwin_io_cmp u_io (
    .word_i    (word_addr),
    .opt_i     (iopage_opt),
    .bank_ok_i (bank_ok),
    .hit_o     (io_hit),
    .off_o     (io_off)
  );

  always_comb begin
    sel_d = main_hit || io_hit;
    if (io_hit)
      local_d = {1'b1, {(MAIN_W-IO_OFF_W){1'b0}}, io_off};
    else if (main_hit)
      local_d = {1'b0, main_local};
    else
      local_d = '0;
  end

  memwin_out #(.REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_d   (sel_d),
    .local_d (local_d),
    .io_d    (io_hit),
    .sel_o   (sel),
    .local_o (local_addr),
    .io_o    (iopage_hit)
  );

  a_r8_bad_bank_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel > BANK_W'(MAX_BANK)) |-> !main_hit && !io_hit);

  a_r5_main_below_io: assert property (@(posedge clk) disable iff (!rst_n)
    main_hit |-> (word_addr < IO_BASE));

  a_r2_single_window: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_hit && io_hit));

  a_r2_local_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
    main_hit |-> ({2'b00, main_local} < cap_words(cap_sel)));

  a_r6_io_opt_valid: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (iopage_opt == IO_OPT_W'(1)) || (iopage_opt == IO_OPT_W'(2)));

  a_r3_byte_lane_free: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(bus_addr_n[ADDR_W-1:1]) && $stable(bank_sel) && $stable(cap_sel) &&
     $stable(iopage_opt) && !$stable(bus_addr_n[0])) |-> $stable(sel_d) && $stable(local_d));
endmodule

// File: tb/memwin_decoder_tb.sv
module memwin_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] bus_addr_n = '1;
  logic [4:0]  bank_sel = '0;
  logic [1:0]  cap_sel = '0;
  logic [1:0]  iopage_opt = '0;
  logic        sel;
  logic [16:0] local_addr;
  logic        iopage_hit;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  memwin_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr_n(bus_addr_n), .bank_sel(bank_sel),
    .cap_sel(cap_sel), .iopage_opt(iopage_opt), .sel(sel),
    .local_addr(local_addr), .iopage_hit(iopage_hit)
  );

  task automatic expect3(input string req, input bit es, input int el, input bit ei);
    checks++;
    if (sel !== es || int'(local_addr) !== el || iopage_hit !== ei) begin
      fails++;
      $display("FAIL %s: got sel=%0b local=%0d io=%0b, expected sel=%0b local=%0d io=%0b",
               req, sel, local_addr, iopage_hit, es, el, ei);
    end
  endtask

  // Independent model, built from the requirement text in word units.
  task automatic model(input int w, input int bank, input int cap, input int opt,
                       output bit es, output int el, output bit ei);
    int lo, hi, iolen;
    es = 0; el = 0; ei = 0;
    if (bank > 28) return;
    lo = bank * 4096;
    hi = lo + (cap + 1) * 16384;
    if (hi > 126976) hi = 126976;
    iolen = (opt == 1) ? 1024 : (opt == 2) ? 2048 : 0;
    if (w >= lo && w < hi) begin
      es = 1; el = w - lo;
    end else if (w >= 126976 && w < 126976 + iolen) begin
      es = 1; ei = 1; el = 65536 + (w - 126976);
    end
  endtask

  task automatic drive(input int w, input bit lane, input int bank, input int cap, input int opt);
    @(negedge clk);
    bus_addr_n = ~{w[16:0], lane};
    bank_sel   = bank[4:0];
    cap_sel    = cap[1:0];
    iopage_opt = opt[1:0];
  endtask

  task automatic probe(input string req, input int w, input bit lane, input int bank,
                       input int cap, input int opt, input bit es, input int el, input bit ei);
    bit ms; int ml; bit mi;
    drive(w, lane, bank, cap, opt);
    @(negedge clk);
    expect3(req, es, el, ei);
    model(w, bank, cap, opt, ms, ml, mi);
    expect3({req, " model"}, ms, ml, mi);
  endtask

  task automatic t_reset;
    drive(8192, 0, 2, 0, 0);
    @(negedge clk);
    expect3("R1 reset", 0, 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_main;
    probe("R2 base", 8192, 0, 2, 0, 0, 1, 0, 0);
    probe("R2 below base", 8191, 0, 2, 0, 0, 0, 0, 0);
    probe("R2 inside", 10000, 0, 2, 0, 0, 1, 1808, 0);
    probe("R2 last", 24575, 0, 2, 0, 0, 1, 16383, 0);
    probe("R10 past end", 24576, 0, 2, 0, 0, 0, 0, 0);
    probe("R2 bank0", 0, 0, 0, 3, 0, 1, 0, 0);
  endtask

  task automatic t_byte_lane;
    probe("R3 lane0", 9000, 0, 2, 1, 0, 1, 808, 0);
    probe("R3 lane1", 9000, 1, 2, 1, 0, 1, 808, 0);
    probe("R3 lane1 miss", 8191, 1, 2, 1, 0, 0, 0, 0);
  endtask

  task automatic t_capacity;
    for (int c = 0; c < 4; c++) begin
      probe("R4 last in", (c + 1) * 16384 - 1, 0, 0, c, 0, 1, (c + 1) * 16384 - 1, 0);
      probe("R4 first out", (c + 1) * 16384, 0, 0, c, 0, 0, 0, 0);
    end
  endtask

  task automatic t_truncate;
    probe("R5 bank28 base", 114688, 0, 28, 3, 0, 1, 0, 0);
    probe("R5 below io", 126975, 0, 28, 3, 0, 1, 12287, 0);
    probe("R5 io page", 126976, 0, 28, 3, 0, 0, 0, 0);
    probe("R5 top", 131071, 0, 28, 3, 2, 0, 0, 0);
  endtask

  task automatic t_iopage;
    probe("R6 opt1 first", 126976, 0, 0, 0, 1, 1, 65536, 1);
    probe("R7 opt1 last", 127999, 0, 0, 0, 1, 1, 66559, 1);
    probe("R6 opt1 beyond", 128000, 0, 0, 0, 1, 0, 0, 0);
    probe("R7 opt2 second k", 128000, 0, 0, 0, 2, 1, 66560, 1);
    probe("R7 opt2 last", 129023, 0, 0, 0, 2, 1, 67583, 1);
    probe("R6 opt2 beyond", 129024, 0, 0, 0, 2, 0, 0, 0);
    probe("R6 opt0", 126976, 0, 0, 0, 0, 0, 0, 0);
    probe("R6 opt3", 126976, 0, 0, 0, 3, 0, 0, 0);
  endtask

  task automatic t_bad_bank;
    probe("R8 bank29 base", 118784, 0, 29, 3, 0, 0, 0, 0);
    probe("R8 bank29 io", 126976, 0, 29, 3, 2, 0, 0, 0);
    probe("R8 bank31 io", 126976, 0, 31, 0, 1, 0, 0, 0);
  endtask

  task automatic t_pipeline;
    probe("R9 prior miss", 100, 0, 1, 0, 0, 0, 0, 0);
    drive(4196, 0, 1, 0, 0);
    #2;
    expect3("R9 before edge", 0, 0, 0);
    @(negedge clk);
    expect3("R9 after edge", 1, 100, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_main();
    t_byte_lane();
    t_capacity();
    t_truncate();
    t_iopage();
    t_bad_bank();
    t_pipeline();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule